// File: doc/BRIEF.md
# Parallel Display Write Controller

This block drives a display over a write-only, strobe-clocked parallel bus in the style of the 8080 interface. Words arrive on a valid/ready stream. Each word carries a flag that marks it as a command or as display data. For each word the block drives chip-select, the write strobe, the data/command line and the data pins. A separate request input drives the display reset line.

Every word takes exactly four ticks of a divided clock, so the word rate is the system clock divided by the divisor and then by four. For example, a 125 MHz clock gives a 32 ns word at divisor 1 and a 64 ns word at divisor 2. The logical data word does not appear on one contiguous run of pins. A mapper spreads it over up to four groups of consecutive pins, and each group is given by a base pin and a pin count. The block checks this configuration and refuses to transfer while it is inconsistent.

Top module: `pdw_par_wr`

## Requirements
- R1: `dc_o` is 0 for the whole of a word whose `in_cmd_i` flag was 1, and 1 for a word whose flag was 0.
- R2: `disp_rst_o` is 1 while `rst_n` is low. After reset it equals `disp_rst_req_i` as sampled at the previous clock edge, and a value of 1 holds the display in reset.
- R3: A word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1. The word then lasts 4·D clocks: `wr_n_o` stays 1 for the first D clocks, is 0 for the next 2·D clocks, and is 1 for the last D clocks.
- R4: `div_m1_i` holds D−1, so values 0 to 65535 select a divisor D from 1 to 65536, and 0 makes one tick equal one clock. The value is sampled when the word is accepted.
- R5: Bit `k` of the logical word goes to the groups in order, lowest bits first. Group g takes the next `cnt_g` bits and places them from pin `base_g` upward. `base_g` is `grp_base_i[g*5 +: 5]` and `cnt_g` is `grp_cnt_i[g*5 +: 5]`, with group 0 in the least significant field.
- R6: Pins that belong to no group are 0 at all times.
- R7: `cs_n_o` falls at acceptance, stays 0 across back-to-back words, and returns to 1 when a word ends with no new word accepted. `wr_n_o` is never 0 while `cs_n_o` is 1.
- R8: `in_ready_o` is 1 while the block is idle and its configuration is valid, and during the last clock of a word's fourth tick. At all other times it is 0.
- R9: `cfg_err_o` is 1 when the group counts do not add up to BUS_W, or when any group's base plus count exceeds PIN_W. While it is 1, `in_ready_o` is 0 and no transfer starts.
- R10: `pins_o` and `dc_o` stay constant from acceptance until the word ends. This includes the rising edge of `wr_n_o`.
- R11: After reset, `cs_n_o` and `wr_n_o` are 1, `pins_o` is 0 and `dc_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Word can be taken this clock |
| in_data_i | input | BUS_W | Logical word |
| in_cmd_i | input | 1 | 1 = command word, 0 = data word |
| div_m1_i | input | 16 | Tick divisor minus one |
| grp_base_i | input | NGRP*5 | Base pin of each group |
| grp_cnt_i | input | NGRP*5 | Pin count of each group |
| disp_rst_req_i | input | 1 | Request to hold the display in reset |
| cfg_err_o | output | 1 | Group configuration inconsistent |
| cs_n_o | output | 1 | Chip-select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dc_o | output | 1 | 0 = command, 1 = data |
| disp_rst_o | output | 1 | Display reset, active high |
| pins_o | output | PIN_W | Scattered data pins |

## Verification
Single words are sent with divisors 1, 2, 3 and 5. This separates a strobe that scales with the divisor from one that is fixed in clock cycles, and it exposes a setup, low or release phase that is off by one tick. Each value pattern puts ones into one group at a time or into all groups. A bit placed in the wrong group, in reversed order, or on an unmapped pin therefore shows at the pins. A back-to-back pair with the valid signal held checks that chip-select stays low and that the two words are spaced 4·D clocks apart. Two broken configurations, one with a wrong sum and one with a group that overruns the pins, must block any transfer.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW1,
    PH_LOW2,
    PH_RELEASE
  } pdw_phase_e;
endpackage

// File: rtl/pdw_tick_gen.sv
module pdw_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_m1_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pdw_pin_map.sv
module pdw_pin_map #(
  parameter int BUS_W  = 16,
  parameter int PIN_W  = 32,
  parameter int NGRP   = 4,
  parameter int PIDX_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic [BUS_W-1:0]       data_i,
  input  logic [NGRP*PIDX_W-1:0] base_i,
  input  logic [NGRP*CNT_W-1:0]  cnt_i,
  output logic [PIN_W-1:0]       pins_o,
  output logic                   cfg_ok_o
);
  function automatic logic cfg_valid(input logic [NGRP*PIDX_W-1:0] b,
                                     input logic [NGRP*CNT_W-1:0] c);
    int sum;
    logic ok;
    sum = 0;
    ok  = 1'b1;
    for (int g = 0; g < NGRP; g++) begin
      sum = sum + int'(c[g*CNT_W +: CNT_W]);
      if (int'(b[g*PIDX_W +: PIDX_W]) + int'(c[g*CNT_W +: CNT_W]) > PIN_W) ok = 1'b0;
    end
    if (sum != BUS_W) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [PIN_W-1:0] scatter(input logic [BUS_W-1:0] d,
                                               input logic [NGRP*PIDX_W-1:0] b,
                                               input logic [NGRP*CNT_W-1:0] c);
    logic [PIN_W-1:0] r;
    int off, base, num;
    r   = '0;
    off = 0;
    for (int g = 0; g < NGRP; g++) begin
      base = int'(b[g*PIDX_W +: PIDX_W]);
      num  = int'(c[g*CNT_W +: CNT_W]);
      for (int k = 0; k < BUS_W; k++) begin
        if (k < num && off + k < BUS_W && base + k < PIN_W) r[base+k] = d[off+k];
      end
      off = off + num;
    end
    return r;
  endfunction

  assign cfg_ok_o = cfg_valid(base_i, cnt_i);
  assign pins_o   = scatter(data_i, base_i, cnt_i);
endmodule

// File: rtl/pdw_bus_seq.sv
module pdw_bus_seq
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       in_valid_i,
  input  logic       cfg_ok_i,
  output logic       in_ready_o,
  output logic       accept_o,
  output logic       busy_o,
  output logic       word_done_o,
  output logic       wr_n_o,
  output logic       cs_n_o
);
  pdw_phase_e ph_q;
  logic       cs_n_q;

  assign word_done_o = (ph_q == PH_RELEASE) && tick_i;
  assign in_ready_o  = cfg_ok_i && ((ph_q == PH_IDLE) || word_done_o);
  assign accept_o    = in_valid_i && in_ready_o;
  assign busy_o      = (ph_q != PH_IDLE);
  assign wr_n_o      = !((ph_q == PH_LOW1) || (ph_q == PH_LOW2));
  assign cs_n_o      = cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cs_n_q <= 1'b1;
    end else if (accept_o) begin
      ph_q   <= PH_SETUP;
      cs_n_q <= 1'b0;
    end else if (word_done_o) begin
      ph_q   <= PH_IDLE;
      cs_n_q <= 1'b1;
    end else if (tick_i) begin
      case (ph_q)
        PH_SETUP: ph_q <= PH_LOW1;
        PH_LOW1:  ph_q <= PH_LOW2;
        PH_LOW2:  ph_q <= PH_RELEASE;
        default:  ph_q <= ph_q;
      endcase
    end
  end
endmodule

// File: rtl/pdw_par_wr.sv
module pdw_par_wr #(
  parameter int BUS_W = 16,
  parameter int PIN_W = 32,
  parameter int NGRP  = 4,
  parameter int DIV_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid_i,
  output logic                             in_ready_o,
  input  logic [BUS_W-1:0]                 in_data_i,
  input  logic                             in_cmd_i,
  input  logic [DIV_W-1:0]                 div_m1_i,
  input  logic [NGRP*$clog2(PIN_W)-1:0]    grp_base_i,
  input  logic [NGRP*$clog2(BUS_W+1)-1:0]  grp_cnt_i,
  input  logic                             disp_rst_req_i,
  output logic                             cfg_err_o,
  output logic                             cs_n_o,
  output logic                             wr_n_o,
  output logic                             dc_o,
  output logic                             disp_rst_o,
  output logic [PIN_W-1:0]                 pins_o
);
  localparam int PIDX_W = $clog2(PIN_W);
  localparam int CNT_W  = $clog2(BUS_W + 1);

  logic             tick, accept, busy, word_done, cfg_ok;
  logic [PIN_W-1:0] pins_next;
  logic [PIN_W-1:0] pins_q;
  logic [DIV_W-1:0] div_q;
  logic             dc_q, rst_q;

  pdw_pin_map #(.BUS_W(BUS_W), .PIN_W(PIN_W), .NGRP(NGRP),
                .PIDX_W(PIDX_W), .CNT_W(CNT_W)) u_map (
    .data_i(in_data_i), .base_i(grp_base_i), .cnt_i(grp_cnt_i),
    .pins_o(pins_next), .cfg_ok_o(cfg_ok)
  );

  pdw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .div_m1_i(div_q), .tick_o(tick)
  );

  pdw_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .in_valid_i(in_valid_i),
    .cfg_ok_i(cfg_ok), .in_ready_o(in_ready_o), .accept_o(accept),
    .busy_o(busy), .word_done_o(word_done), .wr_n_o(wr_n_o), .cs_n_o(cs_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
      div_q  <= '0;
      dc_q   <= 1'b1;
    end else if (accept) begin
      pins_q <= pins_next;
      div_q  <= div_m1_i;
      dc_q   <= !in_cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b1;
    else        rst_q <= disp_rst_req_i;
  end

  assign pins_o     = pins_q;
  assign dc_o       = dc_q;
  assign disp_rst_o = rst_q;
  assign cfg_err_o  = !cfg_ok;
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker #(
  parameter int PIN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cfg_err,
  input logic             cs_n,
  input logic             wr_n,
  input logic             dc,
  input logic [PIN_W-1:0] pins,
  input logic             rst_req,
  input logic             disp_rst,
  input logic             word_done
);
  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !in_ready);

  assert_strobe_in_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  assert_setup_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!cs_n && wr_n));

  assert_hold_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ($stable(pins) && $stable(dc)));

  assert_rst_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> disp_rst);

  assert_ready_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (in_ready || cfg_err));
endmodule

bind pdw_par_wr pdw_checker #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid_i), .in_ready(in_ready_o),
  .cfg_err(cfg_err_o), .cs_n(cs_n_o), .wr_n(wr_n_o), .dc(dc_o), .pins(pins_o),
  .rst_req(disp_rst_req_i), .disp_rst(disp_rst_o), .word_done(word_done)
);

// File: tb/pdw_par_wr_tb.sv
module pdw_par_wr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_cmd = 1'b0;
  logic [15:0] div_m1 = '0;
  logic [19:0] grp_base;
  logic [19:0] grp_cnt;
  logic        rst_req = 1'b1;
  logic        cfg_err, cs_n, wr_n, dc, disp_rst;
  logic [31:0] pins;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [19:0] GOOD_BASE = {5'd25, 5'd20, 5'd12, 5'd2};
  localparam logic [19:0] GOOD_CNT  = {5'd2, 5'd2, 5'd4, 5'd8};

  // entry: {is_cmd, data, divisor-1}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 16'h00FF, 16'd0},
    {1'b0, 16'h0F00, 16'd1},
    {1'b0, 16'h3000, 16'd2},
    {1'b1, 16'hC000, 16'd0},
    {1'b0, 16'hFFFF, 16'd4},
    {1'b0, 16'hA5C3, 16'd1}
  };

  always #2.5 clk = ~clk;

  pdw_par_wr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_cmd_i(in_cmd), .div_m1_i(div_m1),
    .grp_base_i(grp_base), .grp_cnt_i(grp_cnt), .disp_rst_req_i(rst_req),
    .cfg_err_o(cfg_err), .cs_n_o(cs_n), .wr_n_o(wr_n), .dc_o(dc),
    .disp_rst_o(disp_rst), .pins_o(pins)
  );

  function automatic logic [31:0] want_pins(input logic [15:0] d);
    return ({24'b0, d[7:0]} << 2) | ({28'b0, d[11:8]} << 12) |
           ({30'b0, d[13:12]} << 20) | ({30'b0, d[15:14]} << 25);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic one_word(input logic is_cmd, input logic [15:0] d, input logic [15:0] dm1);
    int dv, lows, first_low, hold_bad, rdy_bad;
    dv = int'(dm1) + 1;
    lows = 0; first_low = -1; hold_bad = 0; rdy_bad = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_cmd = is_cmd; div_m1 = dm1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4 * dv; k++) begin
      if (!wr_n) begin
        lows++;
        if (first_low < 0) first_low = k;
      end
      if (pins !== want_pins(d) || dc !== !is_cmd || cs_n !== 1'b0) hold_bad++;
      if (in_ready !== (k == 4 * dv - 1)) rdy_bad++;
      @(negedge clk);
    end
    chk(lows == 2 * dv, "R3 strobe low length", lows, 2 * dv);
    chk(first_low == dv, "R4 strobe fall at divisor", first_low, dv);
    chk(hold_bad == 0, "R10 pins/dc/cs held", hold_bad, 0);
    chk(pins === want_pins(d), "R5 R6 scatter", pins, want_pins(d));
    chk(dc === !is_cmd, "R1 dc level", dc, !is_cmd);
    chk(rdy_bad == 0, "R8 ready only at end", rdy_bad, 0);
    chk(cs_n === 1'b1 && wr_n === 1'b1, "R7 release after word", {cs_n, wr_n}, 2'b11);
  endtask

  initial begin
    #500000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    grp_base = GOOD_BASE;
    grp_cnt  = GOOD_CNT;
    #12;
    // R11 / R2 during reset
    chk(cs_n === 1'b1 && wr_n === 1'b1, "R11 idle strobes", {cs_n, wr_n}, 2'b11);
    chk(pins === 32'h0 && dc === 1'b1, "R11 pins/dc", pins, 0);
    chk(disp_rst === 1'b1, "R2 reset held in block reset", disp_rst, 1);
    @(negedge clk); rst_n = 1'b1;
    rst_req = 1'b0;
    @(negedge clk);
    chk(disp_rst === 1'b0, "R2 follow low", disp_rst, 0);
    chk(in_ready === 1'b1 && cfg_err === 1'b0, "R8 idle ready", {in_ready, cfg_err}, 2'b10);
    rst_req = 1'b1;
    @(negedge clk);
    chk(disp_rst === 1'b1, "R2 follow high", disp_rst, 1);
    rst_req = 1'b0;

    for (int i = 0; i < 6; i++) one_word(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // R7 back-to-back with valid held, divisor 2
    begin
      int f1, f2, cs_bad;
      logic prev;
      f1 = -1; f2 = -1; cs_bad = 0; prev = 1'b1;
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'h1234; in_cmd = 1'b0; div_m1 = 16'd1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_data = 16'h8421;
      for (int k = 0; k < 16; k++) begin
        if (prev && !wr_n) begin
          if (f1 < 0) f1 = k; else f2 = k;
        end
        prev = wr_n;
        if (cs_n !== 1'b0) cs_bad++;
        if (k == 9) chk(pins === want_pins(16'h8421), "R5 second word", pins, want_pins(16'h8421));
        if (k == 8) in_valid = 1'b0;
        @(negedge clk);
      end
      chk(cs_bad == 0, "R7 cs held across words", cs_bad, 0);
      chk(f1 == 2 && f2 == 10, "R3 word spacing", f2 - f1, 8);
      chk(cs_n === 1'b1, "R7 cs released", cs_n, 1);
    end

    // R9 wrong sum
    begin
      int cs_bad;
      cs_bad = 0;
      grp_cnt = {5'd2, 5'd2, 5'd4, 5'd7};
      @(negedge clk);
      chk(cfg_err === 1'b1 && in_ready === 1'b0, "R9 sum error", {cfg_err, in_ready}, 2'b10);
      in_valid = 1'b1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (cs_n !== 1'b1 || wr_n !== 1'b1) cs_bad++;
      end
      chk(cs_bad == 0, "R9 no transfer on sum error", cs_bad, 0);
      in_valid = 1'b0;
      grp_cnt = GOOD_CNT;
      grp_base = {5'd31, 5'd20, 5'd12, 5'd2};
      @(negedge clk);
      chk(cfg_err === 1'b1 && in_ready === 1'b0, "R9 overrun error", {cfg_err, in_ready}, 2'b10);
      grp_base = GOOD_BASE;
      @(negedge clk);
      chk(cfg_err === 1'b0 && cs_n === 1'b1, "R9 recovered", {cfg_err, cs_n}, 2'b01);
    end

    one_word(1'b1, 16'h0001, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule